// File: doc/BRIEF.md
# Random Byte Instruction Decoder

This block turns an untrusted stream of random bytes into well-formed instruction records for a downstream random-arithmetic executor. Any byte sequence is valid input. Each record starts from a control byte. Its low bits choose an operation, with an intentionally skewed spread toward multiplication. Its middle and high bits name a destination register and a source register.

Two operation classes read further bytes before the record is complete. A rotation reads one extra byte, and the sign of that byte picks the direction. An addition reads four extra bytes, which form a 32-bit constant with the least significant byte first.

Bytes enter through a valid/ready handshake, and the finished records leave through a second valid/ready handshake. The decoder holds a single record at a time. It refuses new bytes while a record is waiting at its output.

Top module: `rnd_insn_decoder`

## Requirements
- R1: For each record, the control byte is split as follows: bits 2:0 are the selector, bits 4:3 are `rec_dst`, and bits 7:5 are `rec_src`. R6 describes the one case where `rec_src` is changed.
- R2: The selector maps to `rec_op` as follows:
  - Selectors 0, 1 and 2 give MUL (code 0).
  - Selector 3 gives ADD (code 1).
  - Selector 4 gives SUB (code 2).
  - Selectors 6 and 7 give XOR (code 5).
- R3: Selector 5 reads one more byte. When bit 7 of that byte is 0, the record is ROR (code 3). When bit 7 is 1, the record is ROL (code 4).
- R4: An ADD reads four more bytes. The first of these bytes lands in `rec_const[7:0]` and the last lands in `rec_const[31:24]`.
- R5: For every operation other than ADD, `rec_const` is zero.
- R6: For ADD, SUB or XOR, when the source field equals the destination field, `rec_src` is the destination plus 4.
- R7: Bytes are consumed strictly in order, in the following amounts per record:
  - 2 bytes for a rotation.
  - 5 bytes for an ADD.
  - 1 byte for any other operation.
  
  `byte_ready` is high whenever no record is pending.
- R8: While `rec_valid` is high and `rec_ready` is low, all record outputs hold steady and `byte_ready` stays low.
- R9: Reset drops `rec_valid`, raises `byte_ready` and discards any partly read instruction. The next byte after reset is treated as a control byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_valid | input | 1 | Input byte available |
| byte_data | input | 8 | Input byte |
| byte_ready | output | 1 | Decoder accepts a byte this cycle |
| rec_valid | output | 1 | Instruction record available |
| rec_ready | input | 1 | Consumer takes the record |
| rec_op | output | 3 | Operation code (0 MUL, 1 ADD, 2 SUB, 3 ROR, 4 ROL, 5 XOR) |
| rec_dst | output | 2 | Destination register index |
| rec_src | output | 3 | Source register index |
| rec_const | output | 32 | Addition constant, zero for other operations |

## Verification
The assertions check the following on every cycle:
- The output handshake invariants: the record holds during a stall, and no byte is taken while a record is pending.
- The operation code stays within its legal range.
- The constant is zero for operations other than ADD.
- After substitution, a self-combining operation never names the same register twice.

Some behaviours can only be shown by the bench's scenarios. The bench sweeps all 256 control bytes and interleaves gaps on both handshakes. These scenarios show the following:
- The selector-to-operation mapping.
- The sign-dependent choice of rotation direction, including the bytes 0x7F and 0x80.
- The ordering of the constant bytes.
- The exact number of bytes consumed per record.
- A reset taken in the middle of a constant, which must throw away the partial value.

// File: rtl/rid_pkg.sv
package rid_pkg;
  localparam logic [2:0] OP_MUL = 3'd0;
  localparam logic [2:0] OP_ADD = 3'd1;
  localparam logic [2:0] OP_SUB = 3'd2;
  localparam logic [2:0] OP_ROR = 3'd3;
  localparam logic [2:0] OP_ROL = 3'd4;
  localparam logic [2:0] OP_XOR = 3'd5;

  localparam logic [2:0] SEL_ADD = 3'd3;
  localparam logic [2:0] SEL_SUB = 3'd4;
  localparam logic [2:0] SEL_ROT = 3'd5;

  typedef enum logic [1:0] {
    ST_CTRL  = 2'd0,
    ST_ROT   = 2'd1,
    ST_CONST = 2'd2,
    ST_EMIT  = 2'd3
  } dec_state_e;
endpackage

// File: rtl/rid_ctrl_decode.sv
module rid_ctrl_decode
  import rid_pkg::*;
(
  input  logic [7:0] ctrl_byte,
  output logic [2:0] op,
  output logic       is_rot,
  output logic       is_add,
  output logic [1:0] dst,
  output logic [2:0] src
);
  logic [2:0] sel;
  logic [2:0] raw_src;
  logic       self_ref;

  assign sel     = ctrl_byte[2:0];
  assign dst     = ctrl_byte[4:3];
  assign raw_src = ctrl_byte[7:5];

  always_comb begin
    is_rot = 1'b0;
    is_add = 1'b0;
    unique case (sel)
      3'd0, 3'd1, 3'd2: op = OP_MUL;
      SEL_ADD: begin
        op     = OP_ADD;
        is_add = 1'b1;
      end
      SEL_SUB: op = OP_SUB;
      SEL_ROT: begin
        op     = OP_ROR;
        is_rot = 1'b1;
      end
      default: op = OP_XOR;
    endcase
  end

  // Self-combining operations must not read their own destination.
  assign self_ref = (op == OP_ADD || op == OP_SUB || op == OP_XOR) &&
                    (raw_src == {1'b0, dst});
  assign src = self_ref ? {1'b1, dst} : raw_src;
endmodule

// File: rtl/rid_const_shift.sv
module rid_const_shift #(
  parameter int CONST_BYTES = 4
) (
  input  logic [CONST_BYTES*8-1:0] cur,
  input  logic [7:0]               new_byte,
  output logic [CONST_BYTES*8-1:0] nxt
);
  // Each new byte enters at the top lane and older bytes move down.
  // After CONST_BYTES shifts, the first byte sits in the lowest lane.
  generate
    for (genvar i = 0; i < CONST_BYTES; i++) begin : g_lane
      if (i == CONST_BYTES - 1) begin : g_top
        assign nxt[i*8 +: 8] = new_byte;
      end else begin : g_mid
        assign nxt[i*8 +: 8] = cur[(i+1)*8 +: 8];
      end
    end
  endgenerate
endmodule

// File: rtl/rnd_insn_decoder.sv
module rnd_insn_decoder
  import rid_pkg::*;
#(
  parameter int CONST_BYTES = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     byte_valid,
  input  logic [7:0]               byte_data,
  output logic                     byte_ready,
  output logic                     rec_valid,
  input  logic                     rec_ready,
  output logic [2:0]               rec_op,
  output logic [1:0]               rec_dst,
  output logic [2:0]               rec_src,
  output logic [CONST_BYTES*8-1:0] rec_const
);
  localparam int CONST_W = CONST_BYTES * 8;
  localparam int CNT_W   = (CONST_BYTES > 1) ? $clog2(CONST_BYTES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CONST_BYTES - 1);

  dec_state_e         st_q, st_d;
  logic [2:0]         op_q, op_d;
  logic [1:0]         dst_q, dst_d;
  logic [2:0]         src_q, src_d;
  logic [CONST_W-1:0] c_q, c_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;

  logic [2:0]         dec_op;
  logic               dec_rot, dec_add;
  logic [1:0]         dec_dst;
  logic [2:0]         dec_src;
  logic [CONST_W-1:0] c_shifted;
  logic               byte_take, rec_take, reg_en;

  rid_ctrl_decode u_ctrl (
    .ctrl_byte (byte_data),
    .op        (dec_op),
    .is_rot    (dec_rot),
    .is_add    (dec_add),
    .dst       (dec_dst),
    .src       (dec_src)
  );

  rid_const_shift #(.CONST_BYTES(CONST_BYTES)) u_shift (
    .cur      (c_q),
    .new_byte (byte_data),
    .nxt      (c_shifted)
  );

  assign byte_ready = (st_q != ST_EMIT);
  assign rec_valid  = (st_q == ST_EMIT);
  assign byte_take  = byte_valid && byte_ready;
  assign rec_take   = rec_valid && rec_ready;
  assign reg_en     = byte_take || rec_take;

  always_comb begin
    st_d  = st_q;
    op_d  = op_q;
    dst_d = dst_q;
    src_d = src_q;
    c_d   = c_q;
    cnt_d = cnt_q;
    unique case (st_q)
      ST_CTRL: begin
        if (byte_take) begin
          op_d  = dec_op;
          dst_d = dec_dst;
          src_d = dec_src;
          c_d   = '0;
          cnt_d = '0;
          if (dec_rot)      st_d = ST_ROT;
          else if (dec_add) st_d = ST_CONST;
          else              st_d = ST_EMIT;
        end
      end
      ST_ROT: begin
        if (byte_take) begin
          op_d = byte_data[7] ? OP_ROL : OP_ROR;
          st_d = ST_EMIT;
        end
      end
      ST_CONST: begin
        if (byte_take) begin
          c_d   = c_shifted;
          cnt_d = cnt_q + CNT_W'(1);
          if (cnt_q == CNT_LAST) st_d = ST_EMIT;
        end
      end
      default: begin
        if (rec_take) st_d = ST_CTRL;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_CTRL;
      op_q  <= OP_MUL;
      dst_q <= '0;
      src_q <= '0;
      c_q   <= '0;
      cnt_q <= '0;
    end else if (reg_en) begin
      st_q  <= st_d;
      op_q  <= op_d;
      dst_q <= dst_d;
      src_q <= src_d;
      c_q   <= c_d;
      cnt_q <= cnt_d;
    end
  end

  assign rec_op    = op_q;
  assign rec_dst   = dst_q;
  assign rec_src   = src_q;
  assign rec_const = c_q;
endmodule

// File: rtl/rid_chk.sv
module rid_chk
  import rid_pkg::*;
#(
  parameter int CONST_BYTES = 4
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     byte_ready,
  input logic                     rec_valid,
  input logic                     rec_ready,
  input logic [2:0]               rec_op,
  input logic [1:0]               rec_dst,
  input logic [2:0]               rec_src,
  input logic [CONST_BYTES*8-1:0] rec_const
);
  AST_EMIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid && !rec_ready |=> rec_valid && $stable(rec_op) && $stable(rec_dst) &&
      $stable(rec_src) && $stable(rec_const)); // R8

  AST_NO_BYTE_WHEN_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid |-> !byte_ready); // R8

  AST_READY_WHEN_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    !rec_valid |-> byte_ready); // R7

  AST_CONST_ONLY_ADD: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid && (rec_op != OP_ADD) |-> (rec_const == '0)); // R5

  AST_SRC_DISTINCT: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid && (rec_op == OP_ADD || rec_op == OP_SUB || rec_op == OP_XOR)
      |-> (rec_src != {1'b0, rec_dst})); // R6

  AST_OP_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid |-> (rec_op <= OP_XOR)); // R2
endmodule

bind rnd_insn_decoder rid_chk #(.CONST_BYTES(CONST_BYTES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .byte_ready (byte_ready),
  .rec_valid  (rec_valid),
  .rec_ready  (rec_ready),
  .rec_op     (rec_op),
  .rec_dst    (rec_dst),
  .rec_src    (rec_src),
  .rec_const  (rec_const)
);

// File: tb/rnd_insn_decoder_tb.sv
module rnd_insn_decoder_tb;
  import rid_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        byte_valid;
  logic [7:0]  byte_data;
  logic        byte_ready;
  logic        rec_valid;
  logic        rec_ready;
  logic [2:0]  rec_op;
  logic [1:0]  rec_dst;
  logic [2:0]  rec_src;
  logic [31:0] rec_const;

  always #5 clk = ~clk;

  rnd_insn_decoder u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .byte_valid (byte_valid),
    .byte_data  (byte_data),
    .byte_ready (byte_ready),
    .rec_valid  (rec_valid),
    .rec_ready  (rec_ready),
    .rec_op     (rec_op),
    .rec_dst    (rec_dst),
    .rec_src    (rec_src),
    .rec_const  (rec_const)
  );

  int checks = 0;
  int fails  = 0;

  logic [7:0]  strm  [0:1279];
  logic [2:0]  e_op  [0:255];
  logic [1:0]  e_dst [0:255];
  logic [2:0]  e_src [0:255];
  logic [31:0] e_c   [0:255];
  bit          e_sub [0:255];
  int          e_len [0:255];
  int          nbytes = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] b);
    strm[nbytes] = b;
    nbytes++;
  endtask

  task automatic build();
    for (int c = 0; c < 256; c++) begin
      logic [7:0] cb, r, b0, b1, b2, b3;
      logic [2:0] op, src;
      logic [1:0] dst;
      cb  = 8'(c);
      dst = cb[4:3];
      src = cb[7:5];
      push(cb);
      e_c[c]   = 32'd0;
      e_len[c] = 1;
      case (cb[2:0])
        3'd3: begin
          op = OP_ADD;
          b0 = cb + 8'd1;
          b1 = 8'(c * 3);
          b2 = ~cb;
          b3 = cb ^ 8'hA5;
          if (c == 3)  begin b0 = 8'hFF; b1 = 8'hFF; b2 = 8'hFF; b3 = 8'hFF; end
          if (c == 11) begin b0 = 8'h00; b1 = 8'h00; b2 = 8'h00; b3 = 8'h00; end
          push(b0); push(b1); push(b2); push(b3);
          e_c[c]   = {b3, b2, b1, b0};
          e_len[c] = 5;
        end
        3'd4: op = OP_SUB;
        3'd5: begin
          r = 8'(c * 13 + 7);
          if (c == 5)  r = 8'h7F;
          if (c == 13) r = 8'h80;
          if (c == 21) r = 8'h00;
          if (c == 29) r = 8'hFF;
          push(r);
          op = r[7] ? OP_ROL : OP_ROR;
          e_len[c] = 2;
        end
        3'd6, 3'd7: op = OP_XOR;
        default: op = OP_MUL;
      endcase
      e_sub[c] = 1'b0;
      if ((op == OP_ADD || op == OP_SUB || op == OP_XOR) && src == {1'b0, dst}) begin
        src      = {1'b1, dst};
        e_sub[c] = 1'b1;
      end
      e_op[c]  = op;
      e_dst[c] = dst;
      e_src[c] = src;
    end
  endtask

  initial begin
    int  ptr   = 0;
    int  ri    = 0;
    int  cyc   = 0;
    int  since = 0;
    bit  bf, rf;

    build();
    rst_n      = 1'b0;
    byte_valid = 1'b0;
    byte_data  = 8'h00;
    rec_ready  = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1;
    chk(rec_valid == 1'b0, "R9 reset valid", 32'(rec_valid), 32'd0);
    chk(byte_ready == 1'b1, "R9 reset ready", 32'(byte_ready), 32'd1);
    rst_n = 1'b1;

    // Sweep of all control bytes with gaps on both handshakes.
    while (ri < 256 && cyc < 60000) begin
      @(negedge clk);
      cyc++;
      byte_valid = (ptr < nbytes) && (cyc % 7 != 3);
      byte_data  = (ptr < nbytes) ? strm[ptr] : 8'h00;
      rec_ready  = (cyc % 5 != 1);
      #1;
      bf = byte_valid && byte_ready;
      rf = rec_valid && rec_ready;
      if (rec_valid) begin
        chk(rec_op == e_op[ri], (e_len[ri] == 2) ? "R3 rotation op" : "R2 op map",
            32'(rec_op), 32'(e_op[ri]));
        chk(rec_dst == e_dst[ri], "R1 dst field", 32'(rec_dst), 32'(e_dst[ri]));
        chk(rec_src == e_src[ri], e_sub[ri] ? "R6 src substitute" : "R1 src field",
            32'(rec_src), 32'(e_src[ri]));
        chk(rec_const == e_c[ri], (e_op[ri] == OP_ADD) ? "R4 const order" : "R5 const zero",
            rec_const, e_c[ri]);
        chk(!byte_ready, "R8 no byte while pending", 32'(byte_ready), 32'd0);
      end else begin
        chk(byte_ready, "R7 ready when free", 32'(byte_ready), 32'd1);
      end
      if (rf) chk(since == e_len[ri], "R7 bytes per record", 32'(since), 32'(e_len[ri]));
      @(posedge clk);
      if (bf) begin ptr++; since++; end
      if (rf) begin ri++; since = 0; end
    end
    if (ri < 256) chk(1'b0, "watchdog", 32'(ri), 32'd256);

    // Reset in the middle of a constant must discard it.
    @(negedge clk);
    byte_valid = 1'b1;
    rec_ready  = 1'b1;
    byte_data  = 8'h0B;
    @(negedge clk);
    byte_data  = 8'h11;
    @(negedge clk);
    byte_data  = 8'h22;
    @(negedge clk);
    byte_valid = 1'b0;
    rst_n      = 1'b0;
    #1;
    chk(rec_valid == 1'b0, "R9 mid reset valid", 32'(rec_valid), 32'd0);
    chk(byte_ready == 1'b1, "R9 mid reset ready", 32'(byte_ready), 32'd1);
    @(negedge clk);
    rst_n      = 1'b1;
    byte_valid = 1'b1;
    byte_data  = 8'h0C;
    rec_ready  = 1'b0;
    @(negedge clk);
    byte_valid = 1'b0;
    #1;
    chk(rec_valid == 1'b1, "R9 fresh control", 32'(rec_valid), 32'd1);
    chk(rec_op == OP_SUB, "R9 fresh op", 32'(rec_op), 32'(OP_SUB));
    chk(rec_dst == 2'd1 && rec_src == 3'd0, "R9 fresh fields",
        32'({rec_dst, rec_src}), 32'({2'd1, 3'd0}));
    chk(rec_const == 32'd0, "R9 partial const discarded", rec_const, 32'd0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule